// File: doc/BRIEF.md
# Write-Protected Watchdog Timer

This block is a watchdog built around an 8-bit up-counter that software can load. It advances by one on each count tick from an external prescaler. When a tick arrives while the counter holds its maximum value, the block either raises a chip reset pulse (watchdog mode) or sets an overflow flag and wraps to zero (interval mode). The reset pulse is timed in cycles of a separate slow oscillator clock, not the system clock.

The control bits are guarded against runaway software. Each protected bit has an inhibit companion in the same register. The run bit and the mode bit can only change when a write-enable bit was already set by an earlier access, so starting the watchdog or changing its mode always takes two writes. The timeout is chosen by writing a start value into the counter: the reset comes 256 minus that value ticks later, anywhere from 1 to 256 ticks.

Top module: `wdog_top`

## Requirements
- R1: After reset, reading the control register (offset 0) gives 0x0A, the mode register (offset 1) gives 0x02, the counter (offset 2) gives 0x00, and chip_rst_o is low. Control layout: bit0 run, bit1 run inhibit, bit2 write enable, bit3 write-enable inhibit. Mode layout: bit0 mode (0 watchdog, 1 interval), bit1 mode inhibit, bit2 overflow flag. Inhibit bits always read as 1.
- R2: While run is 1, the counter increases by one on each cycle with tick high. While run is 0, ticks leave it unchanged.
- R3: A write to the control register changes run only if the write-enable bit was already 1 before that write and bit1 of the written data is 0.
- R4: A protected bit whose inhibit bit is written as 1 keeps its old value. The write-enable bit changes only when bit3 is written as 0.
- R5: The mode bit changes only if write enable was already 1 and bit1 of the data written to offset 1 is 0.
- R6: A write to offset 2 loads the counter at any time, and counting resumes from the loaded value. A write in the same cycle as a tick takes priority over the tick.
- R7: In watchdog mode, chip_rst_o rises after exactly 256 minus the loaded value ticks. It stays low after one tick fewer.
- R8: chip_rst_o stays high for exactly PULSE_CYC (default 512) osc_clk cycles.
- R9: While a reset pulse is pending or active, the counter and the control and mode registers are held at their reset values, and writes and ticks have no effect.
- R10: In interval mode, an overflow sets mode bit2, wraps the counter to 0x00 and does not assert chip_rst_o. Writing bit2 of offset 1 as 0 clears the flag.
- R11: One overflow produces exactly one reset pulse, with no retrigger after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, system domain |
| osc_clk | input | 1 | Slow oscillator clock that times the reset pulse |
| osc_rst_n | input | 1 | Synchronous active-low reset, oscillator domain |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset (0 control, 1 mode, 2 counter) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| tick | input | 1 | Prescaled count-enable, one system cycle wide |
| chip_rst_o | output | 1 | Reset pulse output, oscillator domain |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a 512-cycle pulse. It uses an oscillator period three times the system period. With these values the full 256-tick timeout is reachable, and the pulse length is measured exactly against the real 512-cycle figure rather than a scaled-down one. The slower oscillator also exercises both synchronizer directions, so the hold window covers the full handshake latency.

// File: rtl/wdog_pkg.sv
// Package: register offsets and bit positions shared by the watchdog blocks.
// Assumes an 8-bit-or-wider register bus; only the low four bits carry control.
package wdog_pkg;
    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_MODE = 2'd1;
    localparam logic [1:0] ADR_CNT  = 2'd2;

    localparam int B_RUN     = 0;
    localparam int B_RUN_INH = 1;
    localparam int B_WEN     = 2;
    localparam int B_WEN_INH = 3;

    localparam int B_MODE     = 0;
    localparam int B_MODE_INH = 1;
    localparam int B_FLAG     = 2;
endpackage

// File: rtl/wdog_sync.sv
// Two-flop synchronizer into the destination clock domain.
// Assumes the source holds the level for at least two destination cycles.
module wdog_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Shift the async level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wdog_ctrl.sv
// Guarded control and mode registers.
// Each protected bit changes only when its inhibit companion is written 0.
// Run and mode also need write enable already set. hold forces reset values.
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [3:0] wbits,
    input  logic       ovf_irq,
    output logic       run,
    output logic       wren,
    output logic       mode,
    output logic       flag
);
    logic wr_ctrl, wr_mode;

    assign wr_ctrl = wr_en && (addr == ADR_CTRL);
    assign wr_mode = wr_en && (addr == ADR_MODE);

    // Update the protected bits according to their inhibit companions.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            run  <= 1'b0;
            wren <= 1'b0;
            mode <= 1'b0;
        end else begin
            if (wr_ctrl && !wbits[B_WEN_INH])
                wren <= wbits[B_WEN];
            if (wr_ctrl && !wbits[B_RUN_INH] && wren)
                run <= wbits[B_RUN];
            if (wr_mode && !wbits[B_MODE_INH] && wren)
                mode <= wbits[B_MODE];
        end
    end

    // Interval overflow flag: set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            flag <= 1'b0;
        else if (ovf_irq)
            flag <= 1'b1;
        else if (wr_mode && !wbits[B_FLAG])
            flag <= 1'b0;
    end
endmodule

// File: rtl/wdog_counter.sv
// Loadable up-counter that advances on the tick while running.
// A load wins over a tick in the same cycle. ovf marks a tick taken at the maximum.
module wdog_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign ovf = run && tick && !load && !hold && (cnt == CNT_MAX);

    // Count, load or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdog_pulse.sv
// Oscillator-domain pulse generator. It synchronizes the request, then
// drives pulse for exactly PULSE_CYC osc cycles. It ignores the request while busy.
module wdog_pulse #(
    parameter int PULSE_CYC = 512
) (
    input  logic osc_clk,
    input  logic osc_rst_n,
    input  logic req_async,
    output logic pulse
);
    localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(PULSE_CYC - 1);

    logic          req_s;
    logic [PW-1:0] pcnt;

    wdog_sync u_req_sync (
        .clk   (osc_clk),
        .rst_n (osc_rst_n),
        .d     (req_async),
        .q     (req_s)
    );

    // Start on a synchronized request and run until the length is reached.
    always_ff @(posedge osc_clk) begin
        if (!osc_rst_n) begin
            pulse <= 1'b0;
            pcnt  <= '0;
        end else if (pulse) begin
            if (pcnt == LAST) begin
                pulse <= 1'b0;
                pcnt  <= '0;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end else if (req_s) begin
            pulse <= 1'b1;
            pcnt  <= '0;
        end
    end
endmodule

// File: rtl/wdog_top.sv
// Write-protected watchdog top level: register bus, counter, reset request
// handshake and oscillator-timed reset pulse. rdata is combinational.
module wdog_top
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PULSE_CYC = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_clk,
    input  logic             osc_rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic             tick,
    output logic             chip_rst_o
);
    logic             run, wren, mode, flag;
    logic             ovf, rst_req, pulse_s, hold;
    logic [CNT_W-1:0] cnt;

    assign hold = rst_req || pulse_s;

    wdog_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .wr_en   (wr_en),
        .addr    (addr),
        .wbits   (wdata[3:0]),
        .ovf_irq (ovf && mode),
        .run     (run),
        .wren    (wren),
        .mode    (mode),
        .flag    (flag)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .run      (run),
        .tick     (tick),
        .load     (wr_en && (addr == ADR_CNT)),
        .load_val (wdata),
        .cnt      (cnt),
        .ovf      (ovf)
    );

    // Reset request: raised by a watchdog overflow, dropped once the pulse is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else if (ovf && !mode)
            rst_req <= 1'b1;
        else if (pulse_s)
            rst_req <= 1'b0;
    end

    wdog_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .osc_clk   (osc_clk),
        .osc_rst_n (osc_rst_n),
        .req_async (rst_req),
        .pulse     (chip_rst_o)
    );

    wdog_sync u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (chip_rst_o),
        .q     (pulse_s)
    );

    // Register read mux.
    always_comb begin
        case (addr)
            ADR_CTRL: rdata = CNT_W'({1'b1, wren, 1'b1, run});
            ADR_MODE: rdata = CNT_W'({flag, 1'b1, mode});
            ADR_CNT:  rdata = cnt;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_checks.sv
// Assertion checker for wdog_top, attached by bind. It observes internal
// state in both clock domains.
module wdog_checks #(
    parameter int CNT_W     = 8,
    parameter int PULSE_CYC = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_clk,
    input logic             osc_rst_n,
    input logic             tick,
    input logic             load,
    input logic             run,
    input logic             wren,
    input logic             mode,
    input logic             hold,
    input logic             ovf,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt,
    input logic             pulse
);
    localparam int LW = $clog2(PULSE_CYC) + 1;
    logic [LW-1:0] plen;

    // Count consecutive high samples of the pulse.
    always_ff @(posedge osc_clk) begin
        if (!osc_rst_n) plen <= '0;
        else            plen <= pulse ? plen + 1'b1 : '0;
    end

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && !hold) |=> cnt == CNT_W'($past(cnt) + 1'b1));
    a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load && !hold) |=> $stable(cnt));
    a_r3_run_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(wren));
    a_r5_mode_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode) |-> $past(wren));
    a_r7_req: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !mode) |=> rst_req);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0) && !run && !wren && !mode);
    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && mode) |=> (cnt == '0) && !rst_req);
    a_r8_len: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        $fell(pulse) |-> plen == LW'(PULSE_CYC));
    a_r8_bound: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        pulse |-> plen < LW'(PULSE_CYC));
    a_r11_no_retrig: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        $fell(pulse) |=> !pulse);
endmodule

bind wdog_top wdog_checks #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_clk   (osc_clk),
    .osc_rst_n (osc_rst_n),
    .tick      (tick),
    .load      (wr_en && (addr == 2'd2)),
    .run       (run),
    .wren      (wren),
    .mode      (mode),
    .hold      (hold),
    .ovf       (ovf),
    .rst_req   (rst_req),
    .cnt       (cnt),
    .pulse     (chip_rst_o)
);

// File: tb/wdog_top_bench.sv
// Directed bench for wdog_top: one task per scenario, each checking its own results.
module wdog_top_bench;
    logic       clk = 0, osc_clk = 0;
    logic       rst_n = 0, osc_rst_n = 0;
    logic       wr_en = 0, tick = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       chip_rst_o;
    int         checks = 0, errors = 0;

    always #10 clk = ~clk;
    always #30 osc_clk = ~osc_clk;

    wdog_top u_wdog_top (
        .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .tick(tick), .chip_rst_o(chip_rst_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input int exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic start_wdog();
        wr(2'd0, 8'h06);
        wr(2'd0, 8'h05);
    endtask

    // Wait for a rising pulse, measure its length in osc cycles, then confirm no retrigger.
    task automatic expect_pulse(input string req);
        int n = 0;
        int seen = 0;
        for (int i = 0; i < 12 && seen == 0; i++) begin
            @(negedge osc_clk);
            if (chip_rst_o) seen = 1;
        end
        check({req, " R7 pulse raised"}, seen, 1);
        if (seen == 1) begin
            n = 1;
            while (n < 2000) begin
                @(negedge osc_clk);
                if (chip_rst_o) n++; else break;
            end
            check("R8 pulse length", n, 512);
            for (int i = 0; i < 100; i++) begin
                @(negedge osc_clk);
                if (chip_rst_o) begin
                    check("R11 retrigger", 1, 0);
                    break;
                end
            end
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic quiet_check(input string req);
        int hit = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (chip_rst_o) hit = 1;
        end
        check(req, hit, 0);
    endtask

    task automatic t_reset();
        rd_check("R1 ctrl", 2'd0, 8'h0A);
        rd_check("R1 mode", 2'd1, 8'h02);
        rd_check("R1 cnt", 2'd2, 8'h00);
        check("R1 chip_rst_o", chip_rst_o, 0);
    endtask

    task automatic t_guard();
        wr(2'd0, 8'h01);
        rd_check("R3 run without wren", 2'd0, 8'h0A);
        ticks(3);
        rd_check("R2 stopped", 2'd2, 8'h00);
        wr(2'd0, 8'h0C);
        rd_check("R4 wren inhibited", 2'd0, 8'h0A);
        start_wdog();
        rd_check("R3 two-write start", 2'd0, 8'h0F);
        wr(2'd0, 8'h06);
        rd_check("R4 run inhibited", 2'd0, 8'h0F);
    endtask

    task automatic t_count();
        ticks(5);
        rd_check("R2 count", 2'd2, 8'h05);
        repeat (10) @(negedge clk);
        rd_check("R2 no tick", 2'd2, 8'h05);
        wr(2'd2, 8'h80);
        rd_check("R6 load", 2'd2, 8'h80);
        ticks(2);
        rd_check("R6 resume", 2'd2, 8'h82);
        @(negedge clk); wr_en = 1; addr = 2'd2; wdata = 8'h40; tick = 1;
        @(negedge clk); wr_en = 0; tick = 0;
        rd_check("R6 load beats tick", 2'd2, 8'h40);
    endtask

    task automatic t_mode();
        wr(2'd0, 8'h02);
        rd_check("R4 wren cleared", 2'd0, 8'h0B);
        wr(2'd1, 8'h01);
        rd_check("R5 mode locked", 2'd1, 8'h02);
        wr(2'd0, 8'h06);
        wr(2'd1, 8'h01);
        rd_check("R5 mode set", 2'd1, 8'h03);
    endtask

    task automatic t_interval();
        wr(2'd2, 8'hFE);
        ticks(2);
        rd_check("R10 wrap", 2'd2, 8'h00);
        rd_check("R10 flag", 2'd1, 8'h07);
        quiet_check("R10 no reset");
        wr(2'd1, 8'h02);
        rd_check("R10 flag clear", 2'd1, 8'h03);
        wr(2'd1, 8'h00);
        rd_check("R5 back to watchdog", 2'd1, 8'h02);
    endtask

    task automatic t_timeout_f1();
        wr(2'd2, 8'hF1);
        ticks(14);
        rd_check("R7 at max", 2'd2, 8'hFF);
        quiet_check("R7 early");
        fork
            ticks(1);
            expect_pulse("F1");
            begin
                repeat (20) @(negedge clk);
                wr(2'd0, 8'h06);
                ticks(2);
                rd_check("R9 ctrl held", 2'd0, 8'h0A);
                rd_check("R9 mode held", 2'd1, 8'h02);
                rd_check("R9 cnt held", 2'd2, 8'h00);
            end
        join
    endtask

    task automatic t_timeout_edges();
        start_wdog();
        wr(2'd2, 8'hFF);
        fork
            ticks(1);
            expect_pulse("FF period 1");
        join
        start_wdog();
        wr(2'd2, 8'h00);
        ticks(255);
        rd_check("R7 255 ticks", 2'd2, 8'hFF);
        quiet_check("R7 period 256 early");
        fork
            ticks(1);
            expect_pulse("00 period 256");
        join
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge osc_clk);
        rst_n = 1; osc_rst_n = 1;
        @(negedge clk);
        t_reset();
        t_guard();
        t_count();
        t_mode();
        t_interval();
        t_timeout_f1();
        t_timeout_edges();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule